// File: doc/BRIEF.md
# Ternary Line Frame Multiplexer

This block sits between the line coder and the line transceiver of a two-wire subscriber loop modem. It builds each transmit frame and takes received frames apart. Every frame lasts 1 ms and holds 120 ternary symbols, so the line runs at 120 kbaud. Each frame carries three kinds of symbol:

- an 11-symbol Barker synchronisation word,
- one service symbol that forms a 1 kbaud sideband,
- 108 payload symbols that arrive already coded and scrambled.

The sync word and the service symbol bypass the scrambler. Each symbol travels as a 2-bit code: `01` is +, `11` is - and `00` is 0.

On transmit, the block steps through the slot sequence once per symbol enable. It inserts the sync word itself. It pulls a payload or service symbol from upstream with a take strobe on the cycle it uses that symbol. On receive, it correlates the incoming stream against the sync word, acquires and holds frame lock, and hands payload and service symbols downstream with strobes, a slot index and a frame-start pulse. A direction input picks the slot map. The sync word starts at slot 0 in one direction and at slot 60 in the other, about half a frame apart. The same RTL therefore serves at either end of the line.

Top module: `tfm_line_framer`

## Requirements
- R1: Every transmit symbol enable produces one output symbol on the next cycle, with `tx_vld` high. `tx_slot` gives that symbol's slot index, counting 0 to 119 and then wrapping to 0. `tx_frame_start` is high exactly when that slot is 0.
- R2: The sync word occupies slots 0 to 10 when `dir_up` is 0 and slots 60 to 70 when `dir_up` is 1. In time order its symbols are + + + - - - + - - + -, sent as `01` for + and `11` for -.
- R3: The service slot is the slot just after the last sync symbol (slot 11 or slot 71). In that enabled cycle `tx_svc_take` is high and `tx_svc_sym` is sent unchanged.
- R4: The remaining 108 slots of each frame are payload slots. In each of them `tx_pay_take` is high in the enabled cycle and `tx_pay_sym` is sent unchanged. The two take strobes are never high together.
- R5: While `tx_en` is low, the transmitter produces no symbol, raises no take strobe and holds its slot position. When `tx_en` returns, the slot sequence resumes where it stopped.
- R6: The receiver starts from hunting. Its first sync-word match aligns the slot count. `rx_locked` rises in the cycle after the third consecutive match, with matches spaced 120 symbols apart and each ending on the last sync slot.
- R7: While the receiver is not locked, `rx_pay_vld`, `rx_svc_vld` and `rx_frame_start` stay low.
- R8: While the receiver is locked, each received symbol appears on `rx_data` one cycle later, along with its slot index on `rx_slot`. `rx_pay_vld` is high for payload slots and `rx_svc_vld` for the service slot. `rx_frame_start` is high for slot 0.
- R9: A locked receiver drops lock when three consecutive expected sync positions fail to match. One or two misses followed by a match keep it locked.
- R10: `rx_resync` goes high when lock is lost and stays high until the receiver locks again.
- R11: After reset, all strobes, `tx_vld`, `rx_locked` and `rx_resync` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_up | input | 1 | Slot map select: 0 puts the sync word at slot 0, 1 puts it at slot 60 |
| tx_en | input | 1 | Transmit symbol enable |
| tx_pay_sym | input | 2 | Payload symbol offered by the upstream coder |
| tx_svc_sym | input | 2 | Service symbol offered upstream |
| tx_pay_take | output | 1 | Payload symbol consumed in this cycle |
| tx_svc_take | output | 1 | Service symbol consumed in this cycle |
| tx_sym | output | 2 | Transmit line symbol |
| tx_vld | output | 1 | `tx_sym` is new |
| tx_slot | output | 7 | Slot index of `tx_sym` |
| tx_frame_start | output | 1 | `tx_sym` is slot 0 |
| rx_en | input | 1 | Receive symbol enable |
| rx_sym | input | 2 | Received line symbol |
| rx_data | output | 2 | Delivered received symbol |
| rx_pay_vld | output | 1 | `rx_data` is a payload symbol |
| rx_svc_vld | output | 1 | `rx_data` is the service symbol |
| rx_slot | output | 7 | Slot index of `rx_data` |
| rx_frame_start | output | 1 | `rx_data` is slot 0 of a locked frame |
| rx_locked | output | 1 | Receiver holds frame lock |
| rx_resync | output | 1 | Lock was lost and not yet regained |

## Verification
The bench builds the block with its default parameters. These are a 120-symbol frame, sync positions 0 and 60, and thresholds of three hits to lock and three misses to drop lock. With these values, whole multi-frame transmit sequences can be compared slot by slot under both direction settings, and acquisition timing can be checked under both settings too. The same values reach the miss counter's corner: two misses then a hit keeps lock, three misses drop it. Corrupted frames are made by zeroing the first sync symbol. The payload pattern places a zero symbol at least every third slot, so any false sync match would show up as a lock-timing error.

// File: rtl/tfm_pkg.sv
package tfm_pkg;
  typedef logic [1:0] tsym_t;

  localparam tsym_t SYM_ZERO = 2'b00;
  localparam tsym_t SYM_POS  = 2'b01;
  localparam tsym_t SYM_NEG  = 2'b11;

  localparam int SYNC_LEN = 11;

  // Sync symbol i is held in bits [2i+1:2i]; symbol 0 goes on the line first.
  localparam logic [2*SYNC_LEN-1:0] BARKER_WORD = 22'b11_01_11_11_01_11_11_11_01_01_01;

  typedef enum logic [1:0] {RX_HUNT, RX_CHECK, RX_LOCK} rx_state_e;
endpackage

// File: rtl/tfm_slot_map.sv
module tfm_slot_map
  import tfm_pkg::*;
#(
  parameter int FRAME_LEN = 120,
  parameter int SYNC_DN   = 0,
  parameter int SYNC_UP   = 60,
  localparam int POS_W    = $clog2(FRAME_LEN),
  localparam int IDX_W    = $clog2(SYNC_LEN)
) (
  input  logic [POS_W-1:0] pos,
  input  logic             dir_up,
  output logic             is_sync,
  output logic [IDX_W-1:0] sync_idx,
  output logic             is_svc
);
  logic [POS_W-1:0] start;
  logic [POS_W-1:0] offset;

  // Positions before the sync start wrap to large offsets, so they count as payload.
  always_comb begin
    start    = dir_up ? POS_W'(SYNC_UP) : POS_W'(SYNC_DN);
    offset   = pos - start;
    is_sync  = offset < POS_W'(SYNC_LEN);
    is_svc   = offset == POS_W'(SYNC_LEN);
    sync_idx = offset[IDX_W-1:0];
  end
endmodule

// File: rtl/tfm_tx.sv
module tfm_tx
  import tfm_pkg::*;
#(
  parameter int FRAME_LEN = 120,
  parameter int SYNC_DN   = 0,
  parameter int SYNC_UP   = 60,
  localparam int POS_W    = $clog2(FRAME_LEN),
  localparam int IDX_W    = $clog2(SYNC_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_up,
  input  logic             sym_en,
  input  tsym_t            pay_sym,
  input  tsym_t            svc_sym,
  output logic             pay_take,
  output logic             svc_take,
  output tsym_t            out_sym,
  output logic             out_vld,
  output logic [POS_W-1:0] out_slot,
  output logic             out_fstart
);
  logic [POS_W-1:0] pos_q, pos_d;
  logic             is_sync, is_svc;
  logic [IDX_W-1:0] sync_idx;
  tsym_t            sel_sym;

  tfm_slot_map #(.FRAME_LEN(FRAME_LEN), .SYNC_DN(SYNC_DN), .SYNC_UP(SYNC_UP)) u_map (
    .pos(pos_q), .dir_up(dir_up), .is_sync(is_sync), .sync_idx(sync_idx), .is_svc(is_svc)
  );

  always_comb begin
    pos_d = pos_q;
    if (sym_en) pos_d = (pos_q == POS_W'(FRAME_LEN-1)) ? '0 : pos_q + 1'b1;
    if (is_sync)     sel_sym = tsym_t'(BARKER_WORD >> {sync_idx, 1'b0});
    else if (is_svc) sel_sym = svc_sym;
    else             sel_sym = pay_sym;
    svc_take = sym_en & is_svc;
    pay_take = sym_en & ~is_sync & ~is_svc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q      <= '0;
      out_sym    <= SYM_ZERO;
      out_vld    <= 1'b0;
      out_slot   <= '0;
      out_fstart <= 1'b0;
    end else begin
      pos_q      <= pos_d;
      out_vld    <= sym_en;
      out_fstart <= sym_en && (pos_q == '0);
      if (sym_en) begin
        out_sym  <= sel_sym;
        out_slot <= pos_q;
      end
    end
  end

  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_en && pos_q == POS_W'(FRAME_LEN-1)) |=> (pos_q == '0))
    else $error("slot counter did not wrap");

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_en |=> $stable(pos_q))
    else $error("slot moved while idle");

  assert_take_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pay_take, svc_take}))
    else $error("both take strobes high");
endmodule

// File: rtl/tfm_rx.sv
module tfm_rx
  import tfm_pkg::*;
#(
  parameter int FRAME_LEN  = 120,
  parameter int SYNC_DN    = 0,
  parameter int SYNC_UP    = 60,
  parameter int LOCK_HITS  = 3,
  parameter int MISS_LIMIT = 3,
  localparam int POS_W     = $clog2(FRAME_LEN),
  localparam int IDX_W     = $clog2(SYNC_LEN),
  localparam int HIT_W     = $clog2(LOCK_HITS + 1),
  localparam int MISS_W    = $clog2(MISS_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_up,
  input  logic             sym_en,
  input  tsym_t            in_sym,
  output tsym_t            data,
  output logic             pay_vld,
  output logic             svc_vld,
  output logic [POS_W-1:0] slot,
  output logic             fstart,
  output logic             locked,
  output logic             resync
);
  rx_state_e                 state_q, state_d;
  logic [POS_W-1:0]          pos_q, pos_d, pos_inc, realign;
  logic [2*SYNC_LEN-1:0]     win_q, win_d;
  logic [HIT_W-1:0]          hits_q, hits_d;
  logic [MISS_W-1:0]         miss_q, miss_d;
  logic                      resync_q, resync_d;
  logic                      is_sync, is_svc, at_end, match;
  logic [IDX_W-1:0]          sync_idx;

  tfm_slot_map #(.FRAME_LEN(FRAME_LEN), .SYNC_DN(SYNC_DN), .SYNC_UP(SYNC_UP)) u_map (
    .pos(pos_q), .dir_up(dir_up), .is_sync(is_sync), .sync_idx(sync_idx), .is_svc(is_svc)
  );

  always_comb begin
    win_d    = sym_en ? {in_sym, win_q[2*SYNC_LEN-1:2]} : win_q;
    match    = (win_d == BARKER_WORD);
    at_end   = is_sync && (sync_idx == IDX_W'(SYNC_LEN-1));
    pos_inc  = (pos_q == POS_W'(FRAME_LEN-1)) ? '0 : pos_q + 1'b1;
    realign  = (dir_up ? POS_W'(SYNC_UP) : POS_W'(SYNC_DN)) + POS_W'(SYNC_LEN);
    state_d  = state_q;
    pos_d    = pos_q;
    hits_d   = hits_q;
    miss_d   = miss_q;
    resync_d = resync_q;
    if (sym_en) begin
      pos_d = pos_inc;
      case (state_q)
        RX_HUNT: if (match) begin
          pos_d   = realign;
          hits_d  = HIT_W'(1);
          state_d = RX_CHECK;
        end
        RX_CHECK: if (at_end) begin
          if (!match) begin
            state_d = RX_HUNT;
            hits_d  = '0;
          end else if (hits_q == HIT_W'(LOCK_HITS-1)) begin
            state_d  = RX_LOCK;
            hits_d   = '0;
            miss_d   = '0;
            resync_d = 1'b0;
          end else begin
            hits_d = hits_q + 1'b1;
          end
        end
        default: if (at_end) begin
          if (match) begin
            miss_d = '0;
          end else if (miss_q == MISS_W'(MISS_LIMIT-1)) begin
            state_d  = RX_HUNT;
            miss_d   = '0;
            resync_d = 1'b1;
          end else begin
            miss_d = miss_q + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= RX_HUNT;
      pos_q    <= '0;
      win_q    <= '0;
      hits_q   <= '0;
      miss_q   <= '0;
      resync_q <= 1'b0;
      data     <= SYM_ZERO;
      pay_vld  <= 1'b0;
      svc_vld  <= 1'b0;
      slot     <= '0;
      fstart   <= 1'b0;
    end else begin
      state_q  <= state_d;
      pos_q    <= pos_d;
      win_q    <= win_d;
      hits_q   <= hits_d;
      miss_q   <= miss_d;
      resync_q <= resync_d;
      pay_vld  <= sym_en && (state_q == RX_LOCK) && !is_sync && !is_svc;
      svc_vld  <= sym_en && (state_q == RX_LOCK) && is_svc;
      fstart   <= sym_en && (state_q == RX_LOCK) && (pos_q == '0);
      if (sym_en) begin
        data <= in_sym;
        slot <= pos_q;
      end
    end
  end

  assign locked = (state_q == RX_LOCK);
  assign resync = resync_q;

  assert_lock_on_symbol_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(sym_en))
    else $error("lock gained without a symbol");

  assert_quiet_unlocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_vld || svc_vld || fstart) |-> $past(state_q == RX_LOCK))
    else $error("strobe while unlocked");

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pay_vld, svc_vld}))
    else $error("payload and service strobes together");

  assert_resync_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resync |-> !locked)
    else $error("resync flag while locked");
endmodule

// File: rtl/tfm_line_framer.sv
module tfm_line_framer
  import tfm_pkg::*;
#(
  parameter int FRAME_LEN  = 120,
  parameter int SYNC_DN    = 0,
  parameter int SYNC_UP    = 60,
  parameter int LOCK_HITS  = 3,
  parameter int MISS_LIMIT = 3,
  localparam int POS_W     = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_up,
  input  logic             tx_en,
  input  logic [1:0]       tx_pay_sym,
  input  logic [1:0]       tx_svc_sym,
  output logic             tx_pay_take,
  output logic             tx_svc_take,
  output logic [1:0]       tx_sym,
  output logic             tx_vld,
  output logic [POS_W-1:0] tx_slot,
  output logic             tx_frame_start,
  input  logic             rx_en,
  input  logic [1:0]       rx_sym,
  output logic [1:0]       rx_data,
  output logic             rx_pay_vld,
  output logic             rx_svc_vld,
  output logic [POS_W-1:0] rx_slot,
  output logic             rx_frame_start,
  output logic             rx_locked,
  output logic             rx_resync
);
  tfm_tx #(.FRAME_LEN(FRAME_LEN), .SYNC_DN(SYNC_DN), .SYNC_UP(SYNC_UP)) u_tx (
    .clk(clk), .rst_n(rst_n), .dir_up(dir_up), .sym_en(tx_en),
    .pay_sym(tx_pay_sym), .svc_sym(tx_svc_sym),
    .pay_take(tx_pay_take), .svc_take(tx_svc_take),
    .out_sym(tx_sym), .out_vld(tx_vld), .out_slot(tx_slot), .out_fstart(tx_frame_start)
  );

  tfm_rx #(.FRAME_LEN(FRAME_LEN), .SYNC_DN(SYNC_DN), .SYNC_UP(SYNC_UP),
           .LOCK_HITS(LOCK_HITS), .MISS_LIMIT(MISS_LIMIT)) u_rx (
    .clk(clk), .rst_n(rst_n), .dir_up(dir_up), .sym_en(rx_en), .in_sym(rx_sym),
    .data(rx_data), .pay_vld(rx_pay_vld), .svc_vld(rx_svc_vld), .slot(rx_slot),
    .fstart(rx_frame_start), .locked(rx_locked), .resync(rx_resync)
  );
endmodule

// File: tb/test_tfm_line_framer.sv
`timescale 1ns/1ps
module test_tfm_line_framer;
  import tfm_pkg::*;

  localparam int FL = 120;
  localparam int SA = 0;
  localparam int SB = 60;
  localparam int SL = 11;
  localparam bit [0:10] BK_PLUS = 11'b11100010010;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dir_up = 1'b0;
  logic       tx_en = 1'b0;
  logic [1:0] tx_pay_sym = 2'b00;
  logic [1:0] tx_svc_sym = 2'b00;
  logic       rx_en = 1'b0;
  logic [1:0] rx_sym = 2'b00;
  logic       tx_pay_take, tx_svc_take, tx_vld, tx_frame_start;
  logic [1:0] tx_sym, rx_data;
  logic [6:0] tx_slot, rx_slot;
  logic       rx_pay_vld, rx_svc_vld, rx_frame_start, rx_locked, rx_resync;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  tfm_line_framer #(.FRAME_LEN(FL), .SYNC_DN(SA), .SYNC_UP(SB), .LOCK_HITS(3), .MISS_LIMIT(3))
  i_tfm_line_framer (
    .clk(clk), .rst_n(rst_n), .dir_up(dir_up), .tx_en(tx_en),
    .tx_pay_sym(tx_pay_sym), .tx_svc_sym(tx_svc_sym),
    .tx_pay_take(tx_pay_take), .tx_svc_take(tx_svc_take), .tx_sym(tx_sym), .tx_vld(tx_vld),
    .tx_slot(tx_slot), .tx_frame_start(tx_frame_start), .rx_en(rx_en), .rx_sym(rx_sym),
    .rx_data(rx_data), .rx_pay_vld(rx_pay_vld), .rx_svc_vld(rx_svc_vld), .rx_slot(rx_slot),
    .rx_frame_start(rx_frame_start), .rx_locked(rx_locked), .rx_resync(rx_resync)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  function automatic int sstart(bit d);
    return d ? SB : SA;
  endfunction

  function automatic tsym_t pay_of(int n);
    case (n % 3)
      0:       return SYM_ZERO;
      1:       return SYM_POS;
      default: return SYM_NEG;
    endcase
  endfunction

  function automatic tsym_t svc_of(int f);
    return (f % 2 == 1) ? SYM_NEG : SYM_POS;
  endfunction

  function automatic tsym_t line_sym(bit d, int f, int k, bit corrupt);
    int o = k - sstart(d);
    if (o >= 0 && o < SL) begin
      if (o == 0 && corrupt) return SYM_ZERO;
      return BK_PLUS[o] ? SYM_POS : SYM_NEG;
    end
    if (o == SL) return svc_of(f);
    return pay_of(f * FL + k);
  endfunction

  task automatic do_reset(input bit d);
    rst_n = 1'b0; tx_en = 1'b0; rx_en = 1'b0; rx_sym = SYM_ZERO; dir_up = d;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic tx_step(input bit en, input int n, input int f, output bit pt, output bit st);
    tx_en = en; tx_pay_sym = pay_of(n); tx_svc_sym = svc_of(f);
    #1 pt = tx_pay_take; st = tx_svc_take;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    chk("R11", "tx_vld", int'(tx_vld), 0);
    chk("R11", "tx_frame_start", int'(tx_frame_start), 0);
    chk("R11", "rx_locked", int'(rx_locked), 0);
    chk("R11", "rx_resync", int'(rx_resync), 0);
    chk("R11", "rx strobes", int'({rx_pay_vld, rx_svc_vld, rx_frame_start}), 0);
    #1 chk("R11", "tx takes", int'({tx_pay_take, tx_svc_take}), 0);
  endtask

  task automatic t_tx_frames(input bit d);
    bit pt, st;
    do_reset(d);
    for (int n = 0; n < 2 * FL + 5; n++) begin
      int f = n / FL;
      int k = n % FL;
      int o = k - sstart(d);
      bit sy = (o >= 0 && o < SL);
      bit sv = (o == SL);
      string rq = sy ? "R2" : (sv ? "R3" : "R4");
      tx_step(1'b1, n, f, pt, st);
      chk("R4", "tx_pay_take", int'(pt), int'(!sy && !sv));
      chk("R3", "tx_svc_take", int'(st), int'(sv));
      chk("R1", "tx_vld", int'(tx_vld), 1);
      chk("R1", "tx_slot", int'(tx_slot), k);
      chk("R1", "tx_frame_start", int'(tx_frame_start), int'(k == 0));
      chk(rq, "tx_sym", int'(tx_sym), int'(line_sym(d, f, k, 1'b0)));
    end
  endtask

  task automatic t_tx_hold();
    bit pt, st;
    do_reset(1'b0);
    for (int n = 0; n < 30; n++) tx_step(1'b1, n, 0, pt, st);
    for (int i = 0; i < 6; i++) begin
      tx_step(1'b0, 0, 0, pt, st);
      chk("R5", "idle takes", int'({pt, st}), 0);
      chk("R5", "idle tx_vld", int'(tx_vld), 0);
    end
    for (int n = 30; n < 36; n++) begin
      tx_step(1'b1, n, 0, pt, st);
      chk("R5", "resumed tx_slot", int'(tx_slot), n);
      chk("R5", "resumed tx_sym", int'(tx_sym), int'(line_sym(1'b0, 0, n, 1'b0)));
    end
    tx_en = 1'b0;
  endtask

  task automatic t_rx_lock(input bit d);
    int lock_n = 2 * FL + sstart(d) + SL - 1;
    do_reset(d);
    for (int n = 0; n < 4 * FL; n++) begin
      int f = n / FL;
      int k = n % FL;
      int o = k - sstart(d);
      bit live = (n > lock_n);
      bit ep = live && !(o >= 0 && o <= SL);
      bit es = live && (o == SL);
      tsym_t s = line_sym(d, f, k, 1'b0);
      rx_en = 1'b1; rx_sym = s;
      @(posedge clk); #1;
      chk("R6", "rx_locked", int'(rx_locked), int'(n >= lock_n));
      if (!live) begin
        chk("R7", "strobes unlocked", int'({rx_pay_vld, rx_svc_vld, rx_frame_start}), 0);
      end else begin
        chk("R8", "rx_pay_vld", int'(rx_pay_vld), int'(ep));
        chk("R8", "rx_svc_vld", int'(rx_svc_vld), int'(es));
        chk("R8", "rx_frame_start", int'(rx_frame_start), int'(k == 0));
        if (ep || es) begin
          chk("R8", "rx_data", int'(rx_data), int'(s));
          chk("R8", "rx_slot", int'(rx_slot), k);
        end
      end
    end
    rx_en = 1'b0;
  endtask

  task automatic t_rx_loss();
    do_reset(1'b0);
    for (int n = 0; n < 13 * FL; n++) begin
      int f = n / FL;
      int k = n % FL;
      bit bad = (f == 3 || f == 4 || f == 6 || f == 7 || f == 8);
      int e2 = 2 * FL + SL - 1;
      int e8 = 8 * FL + SL - 1;
      int e11 = 11 * FL + SL - 1;
      bit el = (n >= e2 && n < e8) || (n >= e11);
      bit er = (n >= e8 && n < e11);
      rx_en = 1'b1; rx_sym = line_sym(1'b0, f, k, bad);
      @(posedge clk); #1;
      if (n < e11) chk("R9", "rx_locked", int'(rx_locked), int'(el));
      else         chk("R10", "relock", int'(rx_locked), int'(el));
      chk("R10", "rx_resync", int'(rx_resync), int'(er));
    end
    rx_en = 1'b0;
  endtask

  initial begin
    #1000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    t_reset();
    t_tx_frames(1'b0);
    t_tx_frames(1'b1);
    t_tx_hold();
    t_rx_lock(1'b0);
    t_rx_lock(1'b1);
    t_rx_loss();
    report();
    $finish;
  end
endmodule